// File: doc/BRIEF.md
# Floating-Point Add Operand Alignment Stage

This block is the front end of a double-precision add/subtract datapath. It registers two 64-bit binary64 operands and an operation bit. It then sorts each operand into a class and builds its significand. The operand of larger magnitude goes onto a fixed path. The other operand's significand is shifted right by the exponent distance, and it is complemented when the effective operation is a subtraction.

The outputs feed a significand adder directly: two equal-width fields, a carry-in, the tentative exponent and sign, and the class and exception indications that later stages need. The stage does not add, normalize or round.

Top module: `fpadd_align`

## Requirements
- R1: Each operand's class is given as 0 = zero, 1 = denormal, 2 = normal, 3 = infinity, 4 = NaN. The class comes from an exponent of all zeros or all ones together with a fraction that is zero or non-zero.
- R2: A normal operand's significand is a leading 1 followed by its 52-bit fraction. A zero operand's significand is 0. A denormal operand's significand is its fraction followed by one appended 0, and its exponent of 0 is used unchanged.
- R3: A goes to the large path and `swap_o` is 1 when A's exponent is greater, or when the exponents are equal and A's fraction is greater. Otherwise B is on the large path.
- R4: A subtract flips B's sign. `eff_sub_o` is 1 when A's sign and B's flipped sign differ.
- R5: When both operands are infinities and `eff_sub_o` is 1, `invalid_o` is 1 and the large significand is replaced by binary 11 followed by 51 zeros.
- R6: When either exponent is all ones, the small significand is forced to zero before shifting and complementing.
- R7: The small significand is shifted right by the difference between the two exponents. `small_sig_o` is laid out as the significand in [55:3], the guard bit in [2], the round bit in [1], and in [0] the OR of all bits shifted further. `large_sig_o` is the large significand in [55:3] with zeros below.
- R8: `overshift_o` is 1 exactly when the exponent difference is 53 or more.
- R9: For effective subtraction, `small_sig_o` is the bitwise complement of the aligned field and `carry_o` is 1. For addition, the field is passed unchanged and `carry_o` is 0.
- R10: `exp_o` and `sign_o` are the large-path operand's exponent and sign. For B, the sign is the flipped sign.
- R11: Operands presented with `valid_i` are captured on a clock edge. The results and `valid_o` appear after that edge. `valid_o` is 0 in reset and in the cycle after an idle input cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| valid_i | input | 1 | operands present |
| op_a_i | input | 64 | operand A |
| op_b_i | input | 64 | operand B |
| sub_i | input | 1 | 1 = subtract B from A |
| valid_o | output | 1 | outputs hold a result |
| large_sig_o | output | 56 | large-path adder input |
| small_sig_o | output | 56 | aligned, possibly complemented small-path input |
| carry_o | output | 1 | adder carry-in |
| exp_o | output | 11 | tentative result exponent |
| sign_o | output | 1 | tentative result sign |
| eff_sub_o | output | 1 | effective subtraction |
| swap_o | output | 1 | A is on the large path |
| invalid_o | output | 1 | infinity minus infinity |
| overshift_o | output | 1 | exponent difference of 53 or more |
| a_class_o | output | 3 | class of A |
| b_class_o | output | 3 | class of B |

## Verification
The hardest situations to reach are the ones where rare signs and exponents combine. The invalid case needs two infinities whose effective signs differ, and it arises both from a subtract of like-signed infinities and from an add of unlike-signed ones. The overshift boundary needs exponent distances of exactly 52, 53 and beyond, with bits that land in guard, round or only sticky. Directed operands are built exponent by exponent to hit those distances. They are streamed back to back through a scoreboard so that each result lines up with its own operands.

// File: rtl/fpadd_align_pkg.sv
package fpadd_align_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_DENORM = 3'd1,
    CLS_NORM   = 3'd2,
    CLS_INF    = 3'd3,
    CLS_NAN    = 3'd4
  } fp_class_e;
endpackage

// File: rtl/fpa_classify.sv
module fpa_classify
  import fpadd_align_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              exp_ones_o,
  output logic              frac_zero_o,
  output fp_class_e         class_o,
  output logic [FRAC_W:0]   sig_o
);
  logic exp_zero;

  assign exp_zero    = (exp_i == '0);
  assign exp_ones_o  = (exp_i == '1);
  assign frac_zero_o = (frac_i == '0);

  always_comb begin
    if (exp_zero && !frac_zero_o) sig_o = {frac_i, 1'b0};   // denormal: scale up one place
    else                          sig_o = {!exp_zero, frac_i};
  end

  always_comb begin
    if (exp_zero)         class_o = frac_zero_o ? CLS_ZERO : CLS_DENORM;
    else if (exp_ones_o)  class_o = frac_zero_o ? CLS_INF  : CLS_NAN;
    else                  class_o = CLS_NORM;
  end
endmodule

// File: rtl/fpa_order.sv
module fpa_order #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int SIG_W = FRAC_W + 1
) (
  input  logic              sub_i,
  input  logic              sign_a_i,
  input  logic              sign_b_i,
  input  logic [EXP_W-1:0]  exp_a_i,
  input  logic [EXP_W-1:0]  exp_b_i,
  input  logic [FRAC_W-1:0] frac_a_i,
  input  logic [FRAC_W-1:0] frac_b_i,
  input  logic [SIG_W-1:0]  sig_a_i,
  input  logic [SIG_W-1:0]  sig_b_i,
  input  logic              ones_a_i,
  input  logic              ones_b_i,
  input  logic              fzero_a_i,
  input  logic              fzero_b_i,
  output logic              swap_o,
  output logic              eff_sub_o,
  output logic              invalid_o,
  output logic [SIG_W-1:0]  large_sig_o,
  output logic [SIG_W-1:0]  small_sig_o,
  output logic [EXP_W-1:0]  large_exp_o,
  output logic              large_sign_o,
  output logic [EXP_W-1:0]  shamt_o
);
  localparam logic [SIG_W-1:0] NAN_SIG = {2'b11, {(SIG_W-2){1'b0}}};

  logic [EXP_W:0] d_ab, d_ba;
  logic           exp_gt, exp_eq, frac_gt;
  logic           sign_b_eff;
  logic [SIG_W-1:0] xbar_l, xbar_s;

  // both differences; the borrow bits give the relational signals
  assign d_ab    = {1'b0, exp_a_i} - {1'b0, exp_b_i};
  assign d_ba    = {1'b0, exp_b_i} - {1'b0, exp_a_i};
  assign exp_gt  = d_ba[EXP_W];
  assign exp_eq  = (d_ab == '0);
  assign frac_gt = (frac_a_i > frac_b_i);

  assign swap_o     = exp_gt | (exp_eq & frac_gt);
  assign sign_b_eff = sign_b_i ^ sub_i;
  assign eff_sub_o  = sign_a_i ^ sign_b_eff;

  assign xbar_l = swap_o ? sig_a_i : sig_b_i;
  assign xbar_s = swap_o ? sig_b_i : sig_a_i;

  assign invalid_o   = ones_a_i & ones_b_i & fzero_a_i & fzero_b_i & eff_sub_o;
  assign large_sig_o = invalid_o ? NAN_SIG : xbar_l;
  assign small_sig_o = (ones_a_i | ones_b_i) ? '0 : xbar_s;

  assign large_exp_o  = swap_o ? exp_a_i : exp_b_i;
  assign large_sign_o = swap_o ? sign_a_i : sign_b_eff;
  assign shamt_o      = exp_gt ? d_ab[EXP_W-1:0] : d_ba[EXP_W-1:0];
endmodule

// File: rtl/fpa_rshift.sv
module fpa_rshift #(
  parameter int SIG_W = 53,
  parameter int SH_W  = 11,
  localparam int EXT_W = SIG_W + 2
) (
  input  logic [SIG_W-1:0] sig_i,
  input  logic [SH_W-1:0]  shamt_i,
  output logic [EXT_W:0]   field_o,
  output logic             overshift_o
);
  localparam logic [SH_W-1:0] EXT_LIM = SH_W'(EXT_W);
  localparam logic [SH_W-1:0] SIG_LIM = SH_W'(SIG_W);

  logic [EXT_W-1:0] ext, shifted;
  logic             sticky;

  assign ext = {sig_i, 2'b00};

  always_comb begin
    if (shamt_i >= EXT_LIM) shifted = '0;
    else                    shifted = ext >> shamt_i;
  end

  always_comb begin
    sticky = 1'b0;
    for (int i = 0; i < EXT_W; i++) begin
      if (ext[i] && (SH_W'(i) < shamt_i)) sticky = 1'b1;
    end
  end

  assign field_o     = {shifted, sticky};
  assign overshift_o = (shamt_i >= SIG_LIM);
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_align_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [EXP_W+FRAC_W:0]     op_a_i,
  input  logic [EXP_W+FRAC_W:0]     op_b_i,
  input  logic                      sub_i,
  output logic                      valid_o,
  output logic [FRAC_W+3:0]         large_sig_o,
  output logic [FRAC_W+3:0]         small_sig_o,
  output logic                      carry_o,
  output logic [EXP_W-1:0]          exp_o,
  output logic                      sign_o,
  output logic                      eff_sub_o,
  output logic                      swap_o,
  output logic                      invalid_o,
  output logic                      overshift_o,
  output logic [2:0]                a_class_o,
  output logic [2:0]                b_class_o
);
  localparam int FP_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 1;
  localparam int OUT_W = SIG_W + 3;

  logic [FP_W-1:0] op_q [2];
  logic            sub_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q[0] <= '0;
      op_q[1] <= '0;
      sub_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        op_q[0] <= op_a_i;
        op_q[1] <= op_b_i;
        sub_q   <= sub_i;
      end
    end
  end

  logic [EXP_W-1:0]  exp_v   [2];
  logic [FRAC_W-1:0] frac_v  [2];
  logic [SIG_W-1:0]  sig_v   [2];
  logic              ones_v  [2];
  logic              fzero_v [2];
  fp_class_e         cls_v   [2];

  for (genvar g = 0; g < 2; g++) begin : g_cls
    assign exp_v[g]  = op_q[g][FP_W-2:FRAC_W];
    assign frac_v[g] = op_q[g][FRAC_W-1:0];
    fpa_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .exp_i      (exp_v[g]),
      .frac_i     (frac_v[g]),
      .exp_ones_o (ones_v[g]),
      .frac_zero_o(fzero_v[g]),
      .class_o    (cls_v[g]),
      .sig_o      (sig_v[g])
    );
  end

  logic [SIG_W-1:0] lsig, ssig;
  logic [EXP_W-1:0] shamt;
  logic [SIG_W+2:0] field;
  logic             eff_sub;

  fpa_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_order (
    .sub_i       (sub_q),
    .sign_a_i    (op_q[0][FP_W-1]),
    .sign_b_i    (op_q[1][FP_W-1]),
    .exp_a_i     (exp_v[0]),
    .exp_b_i     (exp_v[1]),
    .frac_a_i    (frac_v[0]),
    .frac_b_i    (frac_v[1]),
    .sig_a_i     (sig_v[0]),
    .sig_b_i     (sig_v[1]),
    .ones_a_i    (ones_v[0]),
    .ones_b_i    (ones_v[1]),
    .fzero_a_i   (fzero_v[0]),
    .fzero_b_i   (fzero_v[1]),
    .swap_o      (swap_o),
    .eff_sub_o   (eff_sub),
    .invalid_o   (invalid_o),
    .large_sig_o (lsig),
    .small_sig_o (ssig),
    .large_exp_o (exp_o),
    .large_sign_o(sign_o),
    .shamt_o     (shamt)
  );

  fpa_rshift #(.SIG_W(SIG_W), .SH_W(EXP_W)) u_shift (
    .sig_i      (ssig),
    .shamt_i    (shamt),
    .field_o    (field),
    .overshift_o(overshift_o)
  );

  assign valid_o     = valid_q;
  assign eff_sub_o   = eff_sub;
  assign carry_o     = eff_sub;
  assign large_sig_o = {lsig, 3'b000};
  assign small_sig_o = field ^ {OUT_W{eff_sub}};
  assign a_class_o   = cls_v[0];
  assign b_class_o   = cls_v[1];
endmodule

// File: rtl/fpadd_align_chk.sv
module fpadd_align_chk
  import fpadd_align_pkg::*;
#(
  parameter int OUT_W = 56
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             valid_o,
  input logic             eff_sub_o,
  input logic             invalid_o,
  input logic             overshift_o,
  input logic [OUT_W-1:0] large_sig_o,
  input logic [OUT_W-1:0] small_sig_o,
  input logic [2:0]       a_class_o,
  input logic [2:0]       b_class_o
);
  p_valid_lat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_invalid_cls_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (a_class_o == CLS_INF) && (b_class_o == CLS_INF) && eff_sub_o);

  p_invalid_nan_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> large_sig_o[OUT_W-1 -: 2] == 2'b11);

  p_special_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_class_o >= CLS_INF) || (b_class_o >= CLS_INF)) |->
      (small_sig_o == (eff_sub_o ? {OUT_W{1'b1}} : {OUT_W{1'b0}})));

  p_overshift_main_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overshift_o && !eff_sub_o) |-> small_sig_o[OUT_W-1:3] == '0);
endmodule

bind fpadd_align fpadd_align_chk #(.OUT_W(FRAC_W + 4)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .valid_o    (valid_o),
  .eff_sub_o  (eff_sub_o),
  .invalid_o  (invalid_o),
  .overshift_o(overshift_o),
  .large_sig_o(large_sig_o),
  .small_sig_o(small_sig_o),
  .a_class_o  (a_class_o),
  .b_class_o  (b_class_o)
);

// File: tb/fpadd_align_tb.sv
module fpadd_align_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] op_a_i = '0, op_b_i = '0;
  logic        sub_i = 1'b0;
  logic        valid_o, carry_o, sign_o, eff_sub_o, swap_o, invalid_o, overshift_o;
  logic [55:0] large_sig_o, small_sig_o;
  logic [10:0] exp_o;
  logic [2:0]  a_class_o, b_class_o;

  always #2 clk_i = ~clk_i;

  fpadd_align u_dut (.*);

  typedef struct packed {
    logic [55:0] lg;
    logic [55:0] sm;
    logic        cy;
    logic [10:0] ex;
    logic        sg, es, sw, iv, os;
    logic [2:0]  ac, bc;
  } res_t;

  typedef struct {
    res_t  r;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [2:0] cls_of(logic [63:0] v);
    if (v[62:52] == 11'h000) return (v[51:0] == 0) ? 3'd0 : 3'd1;
    if (v[62:52] == 11'h7FF) return (v[51:0] == 0) ? 3'd3 : 3'd4;
    return 3'd2;
  endfunction

  function automatic logic [52:0] sig_of(logic [63:0] v);
    if (v[62:52] == 0) return {v[51:0], 1'b0};
    return {1'b1, v[51:0]};
  endfunction

  function automatic res_t model(logic [63:0] a, logic [63:0] b, logic s);
    res_t r;
    logic a_big, sb;
    logic [52:0] ls, ss;
    logic [10:0] le, se;
    int unsigned d;
    logic [116:0] wide;
    logic [55:0] fld;
    logic stk;
    a_big = (a[62:52] > b[62:52]) || ((a[62:52] == b[62:52]) && (a[51:0] > b[51:0]));
    sb    = b[63] ^ s;
    r.es  = a[63] ^ sb;
    r.sw  = a_big;
    ls    = a_big ? sig_of(a) : sig_of(b);
    ss    = a_big ? sig_of(b) : sig_of(a);
    le    = a_big ? a[62:52] : b[62:52];
    se    = a_big ? b[62:52] : a[62:52];
    r.ex  = le;
    r.sg  = a_big ? a[63] : sb;
    r.iv  = (cls_of(a) == 3) && (cls_of(b) == 3) && r.es;
    if (r.iv) ls = {2'b11, 51'd0};
    if (a[62:52] == 11'h7FF || b[62:52] == 11'h7FF) ss = '0;
    d = int'(le) - int'(se);
    r.os = (d >= 53);
    wide = (d > 116) ? '0 : ({ss, 64'd0} >> d);
    stk  = (d >= 55) ? (ss != 0) : (wide[61:0] != 0);
    fld  = {wide[116:62], stk};
    r.sm = r.es ? ~fld : fld;
    r.cy = r.es;
    r.lg = {ls, 3'b000};
    r.ac = cls_of(a);
    r.bc = cls_of(b);
    return r;
  endfunction

  task automatic send(logic [63:0] a, logic [63:0] b, logic s, string tag);
    item_t it;
    @(negedge clk_i);
    op_a_i = a; op_b_i = b; sub_i = s; valid_i = 1'b1;
    it.r = model(a, b, s);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic check1(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      res_t act;
      act = '{large_sig_o, small_sig_o, carry_o, exp_o, sign_o, eff_sub_o,
              swap_o, invalid_o, overshift_o, a_class_o, b_class_o};
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected result act=%h exp=none", act);
      end else begin
        item_t it;
        it = q.pop_front();
        if (act !== it.r) begin
          fails++;
          $display("FAIL %s act=%h exp=%h", it.tag, act, it.r);
        end
      end
    end
  end

  localparam logic [63:0] ONE = 64'h3FF0_0000_0000_0000, TWO = 64'h4000_0000_0000_0000,
    ONE5 = 64'h3FF8_0000_0000_0000, MONE = 64'hBFF0_0000_0000_0000,
    PINF = 64'h7FF0_0000_0000_0000, NINF = 64'hFFF0_0000_0000_0000,
    QNAN = 64'h7FF8_0000_0000_0000, DMAX = 64'h000F_FFFF_FFFF_FFFF,
    DMIN = 64'h0000_0000_0000_0001, NMIN = 64'h0010_0000_0000_0000,
    NZERO = 64'h8000_0000_0000_0000;

  initial begin
    repeat (3) @(negedge clk_i);
    check1(valid_o == 1'b0, "R11 reset valid", 64'(valid_o), 0);
    rst_ni = 1'b1;
    send(TWO, ONE, 0, "R3 A larger exp / R1");
    send(ONE, TWO, 0, "R3 B larger exp");
    send(ONE, ONE5, 0, "R3 equal exp fraction compare");
    send(ONE5, ONE, 0, "R3 equal exp A fraction larger");
    send(TWO, ONE, 1, "R4 R9 subtract complement");
    send(TWO, MONE, 1, "R4 sub of negative is add");
    send(ONE, MONE, 0, "R4 add of unlike signs");
    send(PINF, PINF, 1, "R5 inf minus inf");
    send(PINF, NINF, 0, "R5 inf plus neg inf");
    send(PINF, PINF, 0, "R5 inf plus inf not invalid / R6");
    send(ONE, QNAN, 0, "R6 NaN passes");
    send(NINF, ONE, 1, "R6 inf with subtract");
    send(DMAX, NMIN, 0, "R2 denormal vs min normal");
    send(DMIN, DMAX, 1, "R2 two denormals");
    send(NZERO, ONE, 0, "R2 R1 zero operand");
    send(64'h0, NZERO, 1, "R1 zero zero");
    send(ONE, 64'h3CB0_0000_0000_0000, 0, "R8 distance 52");
    send(ONE, 64'h3CA0_0000_0000_0000, 0, "R8 distance 53 guard");
    send(ONE, 64'h3C90_0000_0000_0001, 0, "R7 distance 54 round");
    send(ONE, 64'h3C30_0000_0000_0001, 1, "R7 sticky only");
    send(ONE, 64'h3FD8_0000_0000_0003, 0, "R7 guard round bits");
    send(64'hC1E0_0000_0000_0007, DMIN, 1, "R8 huge distance / R10");
    @(negedge clk_i);
    valid_i = 1'b0;
    @(negedge clk_i);
    check1(valid_o == 1'b0, "R11 idle cycle", 64'(valid_o), 0);
    send(64'hBFF8_0000_0000_0000, ONE, 1, "R10 sign of large A");
    send(ONE, 64'h4008_0000_0000_0000, 1, "R10 flipped sign of large B");
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check1(q.size() == 0, "R11 all results seen", 64'(q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule